// File: doc/BRIEF.md
# I2C Slave Address Match Responder

This block is the target-side engine of a two-wire serial controller. It follows the shared clock and data lines and recognises START and STOP conditions. It shifts in the 7-bit address and direction bit that follow every START. It acknowledges the byte when the address equals its programmed own address with the own-address enable set. It also acknowledges when the byte is the general-call value (all zeros, write) and general-call response is enabled. A match raises a sticky new-match flag, one of two sticky bits saying which kind of match occurred, and a direction bit.

After a match, data moves one byte at a time through a host-side data port. In receive direction each byte is acknowledged and parked in the read register. In transmit direction the block waits for the host to supply each byte. In both cases the clock line is held low until the host services the data port, so the bus master stalls instead of overrunning. A master NACK on a transmitted byte and a STOP ending an addressed transaction raise their own sticky flags. A START while addressed restarts address matching, so a combined write-then-read produces a fresh new-match event.

The state machine has the states IDLE, ADDR (shift address byte), AACK (drive address ACK), RXB (shift data in), RXA (drive data ACK), RXH (hold clock until host read), TXH (hold clock until host write), TXB (shift data out), TXA (sample master ACK), TXW (wait after NACK) and SKIP (not addressed). Any START moves to ADDR and any STOP moves to IDLE. ADDR goes to AACK on a match or SKIP otherwise after the eighth bit. AACK goes to TXH for a read or RXB for a write. RXB goes to RXA, then RXH, then back to RXB on a host read. TXH goes to TXB on a host write, TXB goes to TXA, and TXA goes to TXH on ACK or TXW on NACK.

Top module: `ssr_slave_responder`

## Requirements
- R1: After reset every flag, scl_oe, sda_oe, bus_busy and ctrl_busy read 0.
- R2: An address byte whose upper seven bits equal own_addr while own_en is 1 is acknowledged (data line driven low in the ninth clock), and new_match and own_match are set.
- R3: With own_en at 0 the own address is never acknowledged and sets no flag; an address matching nothing is not acknowledged and sets no flag.
- R4: The byte 0x00 is acknowledged and sets new_match and gc_match only while gc_en is 1; with gc_en at 0, and for the byte 0x01 (general call with read bit) in any case, nothing is acknowledged or flagged.
- R5: xmit_dir equals bit 0 (1 = master reads) of the most recent matched address byte.
- R6: In receive direction each data byte is acknowledged, then data_svc is 1, host_rdata holds the byte (first received bit in bit 7), and scl_oe stays 1 until a host_rd pulse.
- R7: In transmit direction data_svc and scl_oe are 1 until a host_wr pulse; the byte on host_wdata is then sent bit 7 first.
- R8: A NACK from the master after a transmitted byte sets neg_ack and leaves the data line released.
- R9: A STOP while addressed sets slave_stop and returns to idle; a STOP after an unmatched address byte sets no flag.
- R10: A START while addressed re-evaluates the address byte: new_match is set again and xmit_dir takes the new direction bit.
- R11: bus_busy is 1 from any START to the next STOP; ctrl_busy is 1 from an address match to the next START or STOP.
- R12: A flag_clr pulse clears new_match, own_match, gc_match, slave_stop and neg_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| scl_oe | output | 1 | Pull serial clock low (clock stretch) |
| sda_oe | output | 1 | Pull serial data low |
| own_en | input | 1 | Own-address response enable |
| own_addr | input | 7 | Own 7-bit address |
| gc_en | input | 1 | General-call response enable |
| host_wdata | input | 8 | Byte to transmit |
| host_wr | input | 1 | Host write strobe to the data port |
| host_rd | input | 1 | Host read strobe to the data port |
| host_rdata | output | 8 | Last received byte |
| flag_clr | input | 1 | Clear all sticky flags |
| new_match | output | 1 | Sticky: an address match occurred |
| own_match | output | 1 | Sticky: match was on own address |
| gc_match | output | 1 | Sticky: match was a general call |
| xmit_dir | output | 1 | 1 when the block must supply data |
| slave_stop | output | 1 | Sticky: STOP ended an addressed transfer |
| neg_ack | output | 1 | Sticky: master NACKed a sent byte |
| data_svc | output | 1 | Data port needs service; clock held |
| bus_busy | output | 1 | Bus between START and STOP |
| ctrl_busy | output | 1 | Block currently addressed |

## Verification
The address comparator is swept over all 128 address values in three configurations: own address enabled with general call on, own address disabled with general call on, and a different own address with general call off. The ACK bit and the three match flags for each value separate own-address hits from general-call hits and from enable gating. Directed transfers cover a two-byte write, where holding the clock without service shows the stall. They also cover a two-byte read ending in NACK, a write turned into a read by a repeated START, and the general-call byte with the read bit set. Together these separate the direction, stall, NACK and STOP paths.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_AACK, S_RXB, S_RXA, S_RXH,
        S_TXH, S_TXB, S_TXA, S_TXW, S_SKIP
    } ssr_state_t;

    localparam logic [7:0] GC_BYTE = 8'h00;
endpackage

// File: rtl/ssr_line_sync.sv
module ssr_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/ssr_bus_cond.sv
module ssr_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic bus_busy
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            bus_busy <= 1'b0;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (start_det)     bus_busy <= 1'b1;
            else if (stop_det) bus_busy <= 1'b0;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ssr_addr_cmp.sv
module ssr_addr_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] addr_byte,
    input  logic          own_en,
    input  logic [DW-2:0] own_addr,
    input  logic          gc_en,
    output logic          own_hit,
    output logic          gc_hit
);
    import ssr_pkg::*;
    assign own_hit = own_en & (addr_byte[DW-1:1] == own_addr);
    assign gc_hit  = gc_en & (addr_byte == DW'(GC_BYTE));
endmodule

// File: rtl/ssr_slave_responder.sv
module ssr_slave_responder #(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          own_en,
    input  logic [DW-2:0] own_addr,
    input  logic          gc_en,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_wr,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic          flag_clr,
    output logic          new_match,
    output logic          own_match,
    output logic          gc_match,
    output logic          xmit_dir,
    output logic          slave_stop,
    output logic          neg_ack,
    output logic          data_svc,
    output logic          bus_busy,
    output logic          ctrl_busy
);
    import ssr_pkg::*;

    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

    logic [1:0] lines_s;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic own_hit, gc_hit, hit;

    ssr_state_t state, state_nx;
    logic [CNT_W-1:0] bitcnt;
    logic [DW-1:0]    shreg;
    logic [DW-1:0]    rx_data;

    ssr_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    ssr_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .bus_busy(bus_busy)
    );

    ssr_addr_cmp #(.DW(DW)) u_cmp (
        .addr_byte(shreg), .own_en(own_en), .own_addr(own_addr),
        .gc_en(gc_en), .own_hit(own_hit), .gc_hit(gc_hit)
    );
    assign hit = own_hit | gc_hit;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = S_ADDR;
        end else if (stop_det) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: state_nx = S_IDLE;
                S_ADDR: if (scl_fall && bitcnt == FULL) state_nx = hit ? S_AACK : S_SKIP;
                S_AACK: if (scl_fall) state_nx = xmit_dir ? S_TXH : S_RXB;
                S_RXB:  if (scl_fall && bitcnt == FULL) state_nx = S_RXA;
                S_RXA:  if (scl_fall) state_nx = S_RXH;
                S_RXH:  if (host_rd) state_nx = S_RXB;
                S_TXH:  if (host_wr) state_nx = S_TXB;
                S_TXB:  if (scl_fall && bitcnt == LAST) state_nx = S_TXA;
                S_TXA:  if (scl_fall) state_nx = shreg[0] ? S_TXW : S_TXH;
                S_TXW:  state_nx = S_TXW;
                S_SKIP: state_nx = S_SKIP;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            shreg      <= '0;
            rx_data    <= '0;
            new_match  <= 1'b0;
            own_match  <= 1'b0;
            gc_match   <= 1'b0;
            xmit_dir   <= 1'b0;
            slave_stop <= 1'b0;
            neg_ack    <= 1'b0;
        end else begin
            if (flag_clr) begin
                new_match  <= 1'b0;
                own_match  <= 1'b0;
                gc_match   <= 1'b0;
                slave_stop <= 1'b0;
                neg_ack    <= 1'b0;
            end
            if (start_det) begin
                bitcnt <= '0;
            end else if (stop_det) begin
                if (ctrl_busy) slave_stop <= 1'b1;
            end else begin
                unique case (state)
                    S_ADDR, S_RXB: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DW-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == FULL) begin
                            if (state == S_RXB) begin
                                rx_data <= shreg;
                            end else if (hit) begin
                                new_match <= 1'b1;
                                xmit_dir  <= shreg[0];
                                if (own_hit) own_match <= 1'b1;
                                if (gc_hit)  gc_match  <= 1'b1;
                            end
                        end
                    end
                    S_AACK: if (scl_fall) bitcnt <= '0;
                    S_RXH:  if (host_rd)  bitcnt <= '0;
                    S_TXH: if (host_wr) begin
                        shreg  <= host_wdata;
                        bitcnt <= '0;
                    end
                    S_TXB: if (scl_fall && bitcnt != LAST) begin
                        shreg  <= {shreg[DW-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    S_TXA: begin
                        if (scl_rise) shreg[0] <= sda_s;
                        else if (scl_fall && shreg[0]) neg_ack <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = 1'b0;
        scl_oe    = 1'b0;
        data_svc  = 1'b0;
        ctrl_busy = 1'b0;
        unique case (state)
            S_AACK: begin sda_oe = 1'b1; ctrl_busy = 1'b1; end
            S_RXA:  begin sda_oe = 1'b1; ctrl_busy = 1'b1; end
            S_RXH, S_TXH: begin
                scl_oe = 1'b1; data_svc = 1'b1; ctrl_busy = 1'b1;
            end
            S_TXB:  begin sda_oe = ~shreg[DW-1]; ctrl_busy = 1'b1; end
            S_RXB, S_TXA, S_TXW: ctrl_busy = 1'b1;
            default: ;
        endcase
    end
    assign host_rdata = rx_data;

    // assertions
    assert_own_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_match) |-> $past(own_en));
    assert_gc_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_match) |-> $past(gc_en));
    assert_match_has_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(new_match) |-> (own_match || gc_match));
    assert_svc_holds_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_svc |-> scl_oe);
    assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == S_IDLE && !sda_oe && !ctrl_busy));
    assert_busy_follows_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);
endmodule

// File: tb/ssr_slave_responder_test.sv
module ssr_slave_responder_test;
    localparam int Q = 5;

    logic clk = 0, rst_n = 0;
    always #2 clk = ~clk;

    logic m_scl = 1, m_sda = 1;
    logic scl_oe, sda_oe;
    wire  scl_bus = m_scl & ~scl_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    logic       own_en = 1, gc_en = 1;
    logic [6:0] own_addr = 7'h5A;
    logic [7:0] host_wdata = 0;
    logic       host_wr = 0, host_rd = 0, flag_clr = 0;
    logic [7:0] host_rdata;
    logic new_match, own_match, gc_match, xmit_dir, slave_stop, neg_ack;
    logic data_svc, bus_busy, ctrl_busy;

    ssr_slave_responder uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_en(own_en), .own_addr(own_addr),
        .gc_en(gc_en), .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
        .host_rdata(host_rdata), .flag_clr(flag_clr), .new_match(new_match),
        .own_match(own_match), .gc_match(gc_match), .xmit_dir(xmit_dir),
        .slave_stop(slave_stop), .neg_ack(neg_ack), .data_svc(data_svc),
        .bus_busy(bus_busy), .ctrl_busy(ctrl_busy)
    );

    int n_tests = 0, n_fail = 0;
    logic [7:0] tx_q [0:7];
    logic [7:0] rx_log [0:7];
    int tx_idx = 0, rx_idx = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic svc();
        if (data_svc) begin
            if (xmit_dir) begin
                host_wdata = tx_q[tx_idx]; tx_idx++;
                host_wr = 1; tick(1); host_wr = 0;
            end else begin
                rx_log[rx_idx] = host_rdata; rx_idx++;
                host_rd = 1; tick(1); host_rd = 0;
            end
        end
    endtask

    task automatic scl_up();
        m_scl = 1;
        tick(1);
        while (!scl_bus) begin svc(); tick(1); end
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; tick(Q); scl_up(); tick(2*Q); m_scl = 0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1; tick(Q); scl_up(); tick(Q); b = sda_bus; tick(Q); m_scl = 0; tick(Q);
    endtask

    task automatic byte_out(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(ack_n);
    endtask

    task automatic byte_in(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        bit_out(nack);
    endtask

    task automatic do_start();
        m_sda = 1; tick(Q); scl_up(); tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
    endtask

    task automatic do_stop();
        m_sda = 0; tick(Q); scl_up(); tick(Q); m_sda = 1; tick(2*Q);
    endtask

    task automatic clear_flags();
        flag_clr = 1; tick(1); flag_clr = 0; tick(1);
    endtask

    task automatic sweep(input logic en, input logic [6:0] own, input logic gce);
        logic ack_n;
        own_en = en; own_addr = own; gc_en = gce;
        for (int a = 0; a < 128; a++) begin
            automatic bit e_own = en && (a == int'(own));
            automatic bit e_gc  = gce && (a == 0);
            automatic bit e_ack = e_own || e_gc;
            do_start();
            byte_out({a[6:0], 1'b0}, ack_n);
            do_stop();
            // R2 R3 R4 R9: ack and flags follow the address arithmetic
            chk(ack_n == !e_ack, "R2/R3 ack", ack_n, !e_ack);
            chk({new_match, own_match, gc_match} == {e_ack, e_own, e_gc}, "R4 match flags",
                {new_match, own_match, gc_match}, {e_ack, e_own, e_gc});
            chk(slave_stop == e_ack, "R9 stop flag", slave_stop, e_ack);
            clear_flags();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack_n;
        logic [7:0] v;
        tick(3); rst_n = 1; tick(2);
        // R1 reset state
        chk({new_match, own_match, gc_match, slave_stop, neg_ack, data_svc} == 0, "R1 flags",
            {new_match, own_match, gc_match, slave_stop, neg_ack, data_svc}, 0);
        chk({scl_oe, sda_oe, bus_busy, ctrl_busy} == 0, "R1 lines",
            {scl_oe, sda_oe, bus_busy, ctrl_busy}, 0);

        sweep(1'b1, 7'h5A, 1'b1);
        sweep(1'b0, 7'h5A, 1'b1);
        sweep(1'b1, 7'h13, 1'b0);

        own_en = 1; own_addr = 7'h5A; gc_en = 1;

        // Write transaction: R5 R6 R11
        rx_idx = 0;
        do_start();
        chk(bus_busy == 1, "R11 bus busy after start", bus_busy, 1);
        byte_out({7'h5A, 1'b0}, ack_n);
        chk(ack_n == 0, "R2 ack", ack_n, 0);
        chk(xmit_dir == 0, "R5 write dir", xmit_dir, 0);
        chk(ctrl_busy == 1, "R11 ctrl busy", ctrl_busy, 1);
        byte_out(8'hC3, ack_n);
        tick(20);
        chk(ack_n == 0, "R6 data ack", ack_n, 0);
        chk({data_svc, scl_oe} == 2'b11, "R6 stall", {data_svc, scl_oe}, 3);
        chk(host_rdata == 8'hC3, "R6 rdata", host_rdata, 8'hC3);
        byte_out(8'h3C, ack_n);
        do_stop();
        chk(rx_idx == 2 && rx_log[0] == 8'hC3 && rx_log[1] == 8'h3C, "R6 bytes",
            {rx_log[0], rx_log[1]}, 16'hC33C);
        chk(slave_stop == 1, "R9 stop after write", slave_stop, 1);
        chk({bus_busy, ctrl_busy} == 0, "R11 idle after stop", {bus_busy, ctrl_busy}, 0);
        clear_flags();
        chk({new_match, own_match, gc_match, slave_stop, neg_ack} == 0, "R12 clear",
            {new_match, own_match, gc_match, slave_stop, neg_ack}, 0);

        // Read transaction: R5 R7 R8
        tx_q[0] = 8'hA5; tx_q[1] = 8'h0F; tx_idx = 0;
        do_start();
        byte_out({7'h5A, 1'b1}, ack_n);
        tick(4);
        chk(xmit_dir == 1, "R5 read dir", xmit_dir, 1);
        chk({data_svc, scl_oe} == 2'b11, "R7 wait for host", {data_svc, scl_oe}, 3);
        byte_in(1'b0, v);
        chk(v == 8'hA5, "R7 byte 0", v, 8'hA5);
        byte_in(1'b1, v);
        chk(v == 8'h0F, "R7 byte 1", v, 8'h0F);
        tick(4);
        chk(neg_ack == 1 && sda_oe == 0, "R8 nack", {neg_ack, sda_oe}, 2'b10);
        do_stop();
        chk(slave_stop == 1, "R9 stop after read", slave_stop, 1);
        clear_flags();

        // Repeated start: R10
        rx_idx = 0; tx_q[2] = 8'h96; tx_idx = 2;
        do_start();
        byte_out({7'h5A, 1'b0}, ack_n);
        byte_out(8'h77, ack_n);
        clear_flags();
        chk(new_match == 0, "R10 cleared before restart", new_match, 0);
        do_start();
        byte_out({7'h5A, 1'b1}, ack_n);
        chk(ack_n == 0 && new_match == 1 && own_match == 1, "R10 rematch",
            {ack_n, new_match, own_match}, 3'b011);
        chk(xmit_dir == 1, "R10 direction", xmit_dir, 1);
        chk(rx_log[0] == 8'h77, "R6 byte before restart", rx_log[0], 8'h77);
        byte_in(1'b1, v);
        chk(v == 8'h96, "R10 read after restart", v, 8'h96);
        do_stop();
        clear_flags();

        // General call with read bit: R4
        do_start();
        byte_out(8'h01, ack_n);
        do_stop();
        chk(ack_n == 1 && new_match == 0 && gc_match == 0 && slave_stop == 0,
            "R4 gc read ignored", {ack_n, new_match, gc_match, slave_stop}, 4'b1000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule